// File: doc/BRIEF.md
# Fault Exception Frame Pusher

This block writes the seven-word exception frame that a processor core stores on its supervisor stack when an access faults (a bus error or a misaligned address). A single start strobe captures everything the frame needs: the faulting address, the direction of the access, whether it was an instruction fetch, its 3-bit function code, the instruction register, the status register, the program counter and the current stack pointer. The block then issues one 16-bit word write per step through a simple write port with a ready handshake.

The stack grows toward lower addresses. The pointer moves down by two bytes before every write. The words leave in this order: program counter low, program counter high, status register, instruction register, fault address low, fault address high, and last the access status word. When the frame is complete, the lowest word holds the access status word and the fault address sits just above it. After the last write the block pulses a done flag and presents the final stack pointer, which is the initial value minus 14.

Top module: `xframe_pusher`

## Requirements
- R1: After a synchronous active-low reset, `wr_en_o` and `done_o` are low and the block is idle.
- R2: The k-th write (k = 0..6) goes to address `sp_i - 2*(k+1)`. Its data are, in order: pc[15:0], pc[31:16], status register, instruction register, fault address[15:0], fault address[31:16], access status word.
- R3: The access status word has the function code in bits 2:0, and bit 3 = 0 for an instruction access, 1 otherwise. Bit 4 = 1 for a read and 0 for a write. Bits 15:5 are zero.
- R4: While `wr_en_o` is high and `wr_ready_i` is low, `wr_addr_o`, `wr_data_o` and `wr_en_o` hold. The next word is issued only after a cycle in which both are high.
- R5: In the cycle after the seventh accepted write, `done_o` is high for exactly one cycle, `wr_en_o` is low, and `sp_o` equals `sp_i - 14`.
- R6: A start strobe while a frame is in progress or while `done_o` is high is ignored. Input changes after the accepted strobe do not alter the frame.
- R7: Each frame makes exactly seven accepted writes.
- R8: A start strobe seen while idle makes `wr_en_o` rise in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a frame (sampled only when idle) |
| sp_i | input | 32 | Stack pointer before the frame |
| fault_addr_i | input | 32 | Address of the faulting access |
| rd_i | input | 1 | 1 = faulting access was a read, 0 = write |
| not_insn_i | input | 1 | 0 = instruction access, 1 = other |
| fc_i | input | 3 | Function code of the faulting access |
| ir_i | input | 16 | Instruction register |
| sr_i | input | 16 | Status register |
| pc_i | input | 32 | Program counter |
| wr_ready_i | input | 1 | Memory accepts the current word |
| wr_addr_o | output | 32 | Byte address of the current word |
| wr_data_o | output | 16 | Word being written |
| wr_en_o | output | 1 | Write request |
| done_o | output | 1 | One-cycle pulse when the frame is complete |
| sp_o | output | 32 | Stack pointer; final value valid with done_o |

## Verification
The hardest case to reach is a start strobe arriving in the middle of a frame together with new operand values, while the memory is stalling. The bench sweeps all 32 combinations of function code, direction and instruction flag. For each word it varies the stall length, and on selected words it raises start while scrambling every input. Every word must still match the values captured at the first strobe. A second strobe during the done cycle checks that no new frame starts.

// File: rtl/xfp_pkg.sv
// Shared definitions for the fault exception frame pusher.
// Assumes a frame of a fixed number of words; the order lives in xfp_word_mux.
package xfp_pkg;
    localparam int FRAME_WORDS = 7;
    localparam int IDX_W       = $clog2(FRAME_WORDS);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PUSH = 2'd1,
        ST_DONE = 2'd2
    } xfp_state_e;
endpackage

// File: rtl/xfp_seq.sv
// Control sequencer: walks the word index through one frame.
// Assumes the write port completes a word in any cycle where wr_en and ready are both high.
module xfp_seq
    import xfp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             ready_i,
    output logic             load_o,
    output logic             accept_o,
    output logic             last_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             wr_en_o,
    output logic             done_o
);
    xfp_state_e       state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;

    // Decode handshake events from the current state.
    always_comb begin
        load_o   = (state_q == ST_IDLE) && start_i;
        accept_o = (state_q == ST_PUSH) && ready_i;
        last_o   = (idx_q == IDX_W'(FRAME_WORDS - 1));
        wr_en_o  = (state_q == ST_PUSH);
        done_o   = (state_q == ST_DONE);
        idx_o    = idx_q;
    end

    // Next-state and index logic.
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            ST_IDLE: if (start_i) begin
                state_d = ST_PUSH;
                idx_d   = '0;
            end
            ST_PUSH: if (ready_i) begin
                if (last_o) state_d = ST_DONE;
                else        idx_d   = idx_q + 1'b1;
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    // The index never runs past the frame while words are being pushed.
    assert_idx_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> (idx_q <= IDX_W'(FRAME_WORDS - 1)));

    // Done lasts exactly one cycle.
    assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
endmodule

// File: rtl/xfp_capture.sv
// Operand capture: freezes all frame contents on the accepted start strobe.
// Assumes load is asserted only while idle, so later input changes cannot leak in.
module xfp_capture #(
    parameter int AW  = 32,
    parameter int DW  = 16,
    parameter int FCW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load_i,
    input  logic [AW-1:0]  fault_addr_i,
    input  logic           rd_i,
    input  logic           not_insn_i,
    input  logic [FCW-1:0] fc_i,
    input  logic [DW-1:0]  ir_i,
    input  logic [DW-1:0]  sr_i,
    input  logic [AW-1:0]  pc_i,
    output logic [AW-1:0]  fault_addr_o,
    output logic           rd_o,
    output logic           not_insn_o,
    output logic [FCW-1:0] fc_o,
    output logic [DW-1:0]  ir_o,
    output logic [DW-1:0]  sr_o,
    output logic [AW-1:0]  pc_o
);
    // Hold registers loaded once per frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_addr_o <= '0;
            rd_o         <= 1'b0;
            not_insn_o   <= 1'b0;
            fc_o         <= '0;
            ir_o         <= '0;
            sr_o         <= '0;
            pc_o         <= '0;
        end else if (load_i) begin
            fault_addr_o <= fault_addr_i;
            rd_o         <= rd_i;
            not_insn_o   <= not_insn_i;
            fc_o         <= fc_i;
            ir_o         <= ir_i;
            sr_o         <= sr_i;
            pc_o         <= pc_i;
        end
    end
endmodule

// File: rtl/xfp_word_mux.sv
// Word selector: maps the push index to the frame word written at that step.
// Assumes AW is a multiple of DW no larger than 2*DW (address split into two words).
module xfp_word_mux #(
    parameter int AW    = 32,
    parameter int DW    = 16,
    parameter int FCW   = 3,
    parameter int IDX_W = 3
) (
    input  logic [IDX_W-1:0] idx_i,
    input  logic [AW-1:0]    fault_addr_i,
    input  logic             rd_i,
    input  logic             not_insn_i,
    input  logic [FCW-1:0]   fc_i,
    input  logic [DW-1:0]    ir_i,
    input  logic [DW-1:0]    sr_i,
    input  logic [AW-1:0]    pc_i,
    output logic [DW-1:0]    word_o
);
    localparam int HI_W = AW - DW;

    logic [DW-1:0] status_word;
    logic [DW-1:0] pc_hi, addr_hi;

    // Build the access status word: fc low, then instruction/not, then direction, rest zero.
    always_comb begin
        status_word              = '0;
        status_word[FCW-1:0]     = fc_i;
        status_word[FCW]         = not_insn_i;
        status_word[FCW+1]       = rd_i;
    end

    // Upper halves, zero-extended when the address is narrower than two words.
    generate
        if (HI_W == DW) begin : g_full_hi
            always_comb begin
                pc_hi   = pc_i[AW-1:DW];
                addr_hi = fault_addr_i[AW-1:DW];
            end
        end else begin : g_ext_hi
            always_comb begin
                pc_hi   = DW'(pc_i[AW-1:DW]);
                addr_hi = DW'(fault_addr_i[AW-1:DW]);
            end
        end
    endgenerate

    // Push order: PC low, PC high, SR, IR, address low, address high, status word.
    always_comb begin
        unique case (idx_i)
            IDX_W'(0): word_o = pc_i[DW-1:0];
            IDX_W'(1): word_o = pc_hi;
            IDX_W'(2): word_o = sr_i;
            IDX_W'(3): word_o = ir_i;
            IDX_W'(4): word_o = fault_addr_i[DW-1:0];
            IDX_W'(5): word_o = addr_hi;
            default:   word_o = status_word;
        endcase
    end
endmodule

// File: rtl/xfp_ptr.sv
// Stack pointer: predecrements on start and after each accepted non-final write.
// Assumes the stack grows downward in units of one data word.
module xfp_ptr #(
    parameter int AW   = 32,
    parameter int STEP = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic          accept_i,
    input  logic          last_i,
    input  logic [AW-1:0] sp_i,
    output logic [AW-1:0] ptr_o
);
    // Pointer register: first slot below sp on load, then one word lower per write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_o <= '0;
        end else if (load_i) begin
            ptr_o <= sp_i - AW'(STEP);
        end else if (accept_i && !last_i) begin
            ptr_o <= ptr_o - AW'(STEP);
        end
    end
endmodule

// File: rtl/xframe_pusher.sv
// Top: pushes a seven-word fault exception frame onto a downward stack.
// Assumes the caller holds no expectation on outputs except during a frame and the done cycle.
module xframe_pusher
    import xfp_pkg::*;
#(
    parameter int AW  = 32,
    parameter int DW  = 16,
    parameter int FCW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic [AW-1:0]  sp_i,
    input  logic [AW-1:0]  fault_addr_i,
    input  logic           rd_i,
    input  logic           not_insn_i,
    input  logic [FCW-1:0] fc_i,
    input  logic [DW-1:0]  ir_i,
    input  logic [DW-1:0]  sr_i,
    input  logic [AW-1:0]  pc_i,
    input  logic           wr_ready_i,
    output logic [AW-1:0]  wr_addr_o,
    output logic [DW-1:0]  wr_data_o,
    output logic           wr_en_o,
    output logic           done_o,
    output logic [AW-1:0]  sp_o
);
    localparam int STEP = DW / 8;

    logic             load, accept, last;
    logic [IDX_W-1:0] idx;
    logic [AW-1:0]    c_addr, c_pc, ptr;
    logic             c_rd, c_ni;
    logic [FCW-1:0]   c_fc;
    logic [DW-1:0]    c_ir, c_sr;

    xfp_seq u_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .ready_i(wr_ready_i),
        .load_o(load), .accept_o(accept), .last_o(last), .idx_o(idx),
        .wr_en_o(wr_en_o), .done_o(done_o)
    );

    xfp_capture #(.AW(AW), .DW(DW), .FCW(FCW)) u_cap (
        .clk(clk), .rst_n(rst_n), .load_i(load),
        .fault_addr_i(fault_addr_i), .rd_i(rd_i), .not_insn_i(not_insn_i),
        .fc_i(fc_i), .ir_i(ir_i), .sr_i(sr_i), .pc_i(pc_i),
        .fault_addr_o(c_addr), .rd_o(c_rd), .not_insn_o(c_ni),
        .fc_o(c_fc), .ir_o(c_ir), .sr_o(c_sr), .pc_o(c_pc)
    );

    xfp_word_mux #(.AW(AW), .DW(DW), .FCW(FCW), .IDX_W(IDX_W)) u_mux (
        .idx_i(idx), .fault_addr_i(c_addr), .rd_i(c_rd), .not_insn_i(c_ni),
        .fc_i(c_fc), .ir_i(c_ir), .sr_i(c_sr), .pc_i(c_pc), .word_o(wr_data_o)
    );

    xfp_ptr #(.AW(AW), .STEP(STEP)) u_ptr (
        .clk(clk), .rst_n(rst_n), .load_i(load), .accept_i(accept),
        .last_i(last), .sp_i(sp_i), .ptr_o(ptr)
    );

    // Drive the port-level address and pointer from the shared pointer register.
    always_comb begin
        wr_addr_o = ptr;
        sp_o      = ptr;
    end

    // A stalled write holds its address, data and request.
    assert_stall_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && !wr_ready_i) |=> (wr_en_o && $stable(wr_addr_o) && $stable(wr_data_o)));

    // Each accepted non-final word is followed by a word two bytes lower.
    assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && wr_ready_i) |=> (done_o || (wr_addr_o == $past(wr_addr_o) - AW'(STEP))));

    // Request and completion never coincide.
    assert_done_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && wr_en_o));

    // Start while idle raises the request in the next cycle.
    assert_start_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_o && !done_o && start_i) |=> wr_en_o);

    // The pointer does not move during a done cycle's following idle entry.
    assert_final_ptr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> $stable(sp_o) || wr_en_o);
endmodule

// File: tb/tb_xframe_pusher.sv
module tb_xframe_pusher;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] sp_i = '0, fault_addr_i = '0, pc_i = '0;
    logic        rd_i = 1'b0, not_insn_i = 1'b0;
    logic [2:0]  fc_i = '0;
    logic [15:0] ir_i = '0, sr_i = '0;
    logic        wr_ready_i = 1'b0;
    logic [31:0] wr_addr_o, sp_o;
    logic [15:0] wr_data_o;
    logic        wr_en_o, done_o;

    int checks = 0;
    int fails  = 0;
    int writes = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xframe_pusher dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .sp_i(sp_i),
        .fault_addr_i(fault_addr_i), .rd_i(rd_i), .not_insn_i(not_insn_i),
        .fc_i(fc_i), .ir_i(ir_i), .sr_i(sr_i), .pc_i(pc_i),
        .wr_ready_i(wr_ready_i), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
        .wr_en_o(wr_en_o), .done_o(done_o), .sp_o(sp_o)
    );

    // Count accepted writes at the clock edge (R7).
    always @(posedge clk) if (rst_n && wr_en_o && wr_ready_i) writes++;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Expected word k of the frame, from the requirement order (R2, R3).
    function automatic logic [15:0] exp_word(input int k, input logic [31:0] pc,
            input logic [31:0] fa, input logic [15:0] ir, input logic [15:0] sr,
            input logic rd, input logic ni, input logic [2:0] fc);
        case (k)
            0: return pc[15:0];
            1: return pc[31:16];
            2: return sr;
            3: return ir;
            4: return fa[15:0];
            5: return fa[31:16];
            default: return {11'b0, rd, ni, fc};
        endcase
    endfunction

    task automatic run_frame(input int f);
        logic [31:0] e_sp, e_pc, e_fa;
        logic [15:0] e_ir, e_sr;
        logic        e_rd, e_ni;
        logic [2:0]  e_fc;
        int          w0;
        e_fc = f[2:0];
        e_ni = f[3];
        e_rd = f[4];
        e_sp = 32'h0001_0000 + 32'(f) * 32'd130;
        e_pc = 32'h0040_1000 + 32'(f) * 32'h0003_0105;
        e_fa = 32'hA5C0_0001 + 32'(f) * 32'h0101_0011;
        e_ir = 16'h4E40 + 16'(f);
        e_sr = 16'h2700 ^ (16'(f) << 3);
        @(negedge clk);
        sp_i = e_sp; pc_i = e_pc; fault_addr_i = e_fa; ir_i = e_ir; sr_i = e_sr;
        rd_i = e_rd; not_insn_i = e_ni; fc_i = e_fc;
        start_i = 1'b1;
        w0 = writes;
        @(negedge clk);
        start_i = 1'b0;
        chk("R8 wr_en after start", 32'(wr_en_o), 32'd1);
        for (int k = 0; k < 7; k++) begin
            for (int d = 0; d < (k + f) % 3; d++) begin
                chk("R4 stall en", 32'(wr_en_o), 32'd1);
                chk("R4 stall addr", wr_addr_o, e_sp - 32'(2 * (k + 1)));
                chk("R4 stall data", 32'(wr_data_o),
                    32'(exp_word(k, e_pc, e_fa, e_ir, e_sr, e_rd, e_ni, e_fc)));
                @(negedge clk);
            end
            wr_ready_i = 1'b1;
            chk("R2 addr", wr_addr_o, e_sp - 32'(2 * (k + 1)));
            if (k == 6)
                chk("R3 status word", 32'(wr_data_o), 32'({11'b0, e_rd, e_ni, e_fc}));
            else
                chk("R2 data", 32'(wr_data_o),
                    32'(exp_word(k, e_pc, e_fa, e_ir, e_sr, e_rd, e_ni, e_fc)));
            if (k == (f % 5) + 1) begin
                // Mid-frame strobe with scrambled inputs must be ignored (R6).
                start_i = 1'b1;
                sp_i = ~e_sp; pc_i = ~e_pc; fault_addr_i = ~e_fa; ir_i = ~e_ir;
                sr_i = ~e_sr; rd_i = ~e_rd; not_insn_i = ~e_ni; fc_i = ~e_fc;
            end
            @(negedge clk);
            wr_ready_i = 1'b0;
            start_i = 1'b0;
        end
        chk("R5 done", 32'(done_o), 32'd1);
        chk("R5 no write in done", 32'(wr_en_o), 32'd0);
        chk("R5 final sp", sp_o, e_sp - 32'd14);
        chk("R7 seven writes", 32'(writes - w0), 32'd7);
        if (f % 2 == 0) start_i = 1'b1;   // strobe in done cycle (R6)
        @(negedge clk);
        start_i = 1'b0;
        chk("R5 done single", 32'(done_o), 32'd0);
        chk("R6 start in done ignored", 32'(wr_en_o), 32'd0);
        @(negedge clk);
        chk("R6 still idle", 32'(wr_en_o), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 wr_en reset", 32'(wr_en_o), 32'd0);
        chk("R1 done reset", 32'(done_o), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", 32'(wr_en_o), 32'd0);
        for (int f = 0; f < 32; f++) run_frame(f);
        if (!finished) begin
            finished = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule